// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block is a purely combinational 32-bit datapath for packed integer arithmetic. Each operand word is viewed either as two independent 16-bit halves or as four independent 8-bit bytes. The block adds or subtracts lane by lane, performs cross forms that pair the high half of one operand with the low half of the other, and computes a byte-wise sum of absolute differences with an optional 32-bit accumulator.

A 6-bit select chooses the operation and the arithmetic flavour: signed or unsigned, combined with modular (flag-producing), saturating or halving arithmetic. Beside the 32-bit result the block drives a 4-bit greater-or-equal flag vector, one bit per byte position, together with a write strobe that tells the surrounding core when those flags are to be committed. A later byte-select step can then consume the flags. Operand fetch, decode, condition evaluation and pipeline staging belong to the surrounding core.

Top module: `simd_addsub`

## Requirements
- R1: opSel[5:3] selects the operation: 0 = halfword add, 3 = halfword subtract, 4 = byte add, 5 = byte subtract. Halves occupy bits [31:16] (high) and [15:0] (low); byte i occupies bits [8i+7:8i]. Lanes are independent, and with modular flavour each lane returns its sum or difference modulo 2^width.
- R2: opSel[5:3] = 1 gives high = high(A) + low(B) and low = low(A) - high(B); opSel[5:3] = 2 gives high = high(A) - low(B) and low = low(A) + high(B).
- R3: opSel[2] = 1 means unsigned lanes and 0 means signed lanes; opSel[1:0] = 00 is modular, 01 is saturating, and both 10 and 11 are halving.
- R4: Saturating flavours clamp each lane to [-2^(w-1), 2^(w-1)-1] when signed and to [0, 2^w-1] when unsigned.
- R5: Halving flavours return bits [w:1] of the exact (w+1)-bit lane sum or difference (arithmetic shift for signed, logical for unsigned).
- R6: geWrite is 1 exactly when opSel[5:3] is 0 to 5 and opSel[1:0] = 00; whenever geWrite is 0, geFlags is 0.
- R7: A lane's flag is 1 when: signed, the exact result is zero or positive; unsigned add, the lane carries out; unsigned subtract, no borrow occurs.
- R8: In halfword operations the high lane's flag drives geFlags[3:2] and the low lane's flag drives geFlags[1:0]; in byte operations byte i drives geFlags[i].
- R9: opSel[5:3] = 6 returns the sum of the four unsigned absolute byte differences |A_i - B_i|, zero-extended; opSel[5:3] = 7 adds accIn to that sum modulo 2^32; opSel[2:0] has no effect on either.
- R10: accIn has no effect on the result or the flags for opSel[5:3] = 0 to 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First packed operand |
| opB | input | 32 | Second packed operand |
| accIn | input | 32 | Accumulator added by the accumulating difference-sum operation |
| opSel | input | 6 | Operation in [5:3], signedness in [2], flavour in [1:0] |
| result | output | 32 | Packed or scalar result |
| geFlags | output | 4 | Per-byte greater-or-equal flags |
| geWrite | output | 1 | High when geFlags are to be committed |

## Verification
The hardest situations to reach are the lane edges where the exact result just leaves its range: a signed halfword sum of 0x7FFF and 1, an unsigned byte subtraction that borrows by one, or a halving subtract whose exact result is -1. Random words almost never sit on these edges, so the stimulus crosses a fixed set of edge words (all-zero, all-one, per-lane minimum and maximum, mixed lanes) with every one of the 64 select codes, then adds random operand pairs over the full select space. The accumulator is varied independently of the select so that its influence outside the accumulating operation would show up in the result.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int SEL_W = 6;

  typedef enum logic [1:0] {
    FL_WRAP = 2'd0,
    FL_SAT  = 2'd1,
    FL_HALF = 2'd2
  } flav_e;

  typedef enum logic [2:0] {
    OP_ADD16 = 3'd0,
    OP_ASX   = 3'd1,
    OP_SAX   = 3'd2,
    OP_SUB16 = 3'd3,
    OP_ADD8  = 3'd4,
    OP_SUB8  = 3'd5,
    OP_SAD   = 3'd6,
    OP_SADA  = 3'd7
  } op_e;

  typedef struct packed {
    logic  byteMode;
    logic  hiSub;
    logic  loSub;
    logic  crossB;
    logic  unsignedOp;
    flav_e flav;
    logic  sadSel;
    logic  accAdd;
    logic  geWe;
  } strobe_t;

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic [SEL_W-1:0] opSel,
  output strobe_t          strobes
);

  op_e   op;
  flav_e flav;

  always_comb begin
    op = op_e'(opSel[5:3]);
    unique case (opSel[1:0])
      2'b00:   flav = FL_WRAP;
      2'b01:   flav = FL_SAT;
      default: flav = FL_HALF;
    endcase
  end

  always_comb begin
    strobes            = '0;
    strobes.unsignedOp = opSel[2];
    strobes.flav       = flav;
    unique case (op)
      OP_ADD16: ;
      OP_ASX: begin
        strobes.crossB = 1'b1;
        strobes.loSub  = 1'b1;
      end
      OP_SAX: begin
        strobes.crossB = 1'b1;
        strobes.hiSub  = 1'b1;
      end
      OP_SUB16: begin
        strobes.hiSub = 1'b1;
        strobes.loSub = 1'b1;
      end
      OP_ADD8: strobes.byteMode = 1'b1;
      OP_SUB8: begin
        strobes.byteMode = 1'b1;
        strobes.hiSub    = 1'b1;
        strobes.loSub    = 1'b1;
      end
      OP_SAD:  strobes.sadSel = 1'b1;
      OP_SADA: begin
        strobes.sadSel = 1'b1;
        strobes.accAdd = 1'b1;
      end
      default: ;
    endcase
    strobes.geWe = !strobes.sadSel && (flav == FL_WRAP);
  end

endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         uns,
  input  flav_e        flav,
  output logic [W-1:0] res,
  output logic         ge
);

  localparam int EW = W + 2;
  localparam logic [W-1:0] UMAX = {W{1'b1}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [EW-1:0] extA, extB, exact;
  logic          neg, ovf;
  logic [W-1:0]  satVal;

  always_comb begin
    extA  = uns ? {2'b00, a} : {{2{a[W-1]}}, a};
    extB  = uns ? {2'b00, b} : {{2{b[W-1]}}, b};
    exact = sub ? (extA - extB) : (extA + extB);
    neg   = exact[EW-1];
    ge    = (uns && !sub) ? exact[W] : !neg;
    ovf   = exact[W] != exact[W-1];
    if (uns) begin
      if (neg)           satVal = '0;
      else if (exact[W]) satVal = UMAX;
      else               satVal = exact[W-1:0];
    end else begin
      if (ovf)           satVal = neg ? SMIN : SMAX;
      else               satVal = exact[W-1:0];
    end
    unique case (flav)
      FL_SAT:  res = satVal;
      FL_HALF: res = exact[W:1];
      default: res = exact[W-1:0];
    endcase
  end

endmodule

// File: rtl/simd_sad.sv
module simd_sad #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] accIn,
  input  logic              accAdd,
  output logic [DATA_W-1:0] sum
);

  localparam int BW = DATA_W / 4;

  logic [BW-1:0] absDiff [4];

  for (genvar i = 0; i < 4; i++) begin : g_diff
    logic [BW:0] d;
    assign d          = {1'b0, opA[i*BW +: BW]} - {1'b0, opB[i*BW +: BW]};
    assign absDiff[i] = d[BW] ? BW'(-d) : d[BW-1:0];
  end

  always_comb begin
    sum = accAdd ? accIn : '0;
    for (int i = 0; i < 4; i++) begin
      sum = sum + DATA_W'(absDiff[i]);
    end
  end

endmodule

// File: rtl/simd_dp.sv
module simd_dp
  import simd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] accIn,
  input  strobe_t           strobes,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        geFlags
);

  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = DATA_W / 4;

  logic [DATA_W-1:0] halfWord, byteWord, sadWord;
  logic [1:0]        halfGe;
  logic [3:0]        byteGe;

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam int OTHER = 1 - h;
    logic [HALF_W-1:0] bSel;
    assign bSel = strobes.crossB ? opB[OTHER*HALF_W +: HALF_W] : opB[h*HALF_W +: HALF_W];
    simd_lane #(.W(HALF_W)) u_lane (
      .a    (opA[h*HALF_W +: HALF_W]),
      .b    (bSel),
      .sub  ((h == 1) ? strobes.hiSub : strobes.loSub),
      .uns  (strobes.unsignedOp),
      .flav (strobes.flav),
      .res  (halfWord[h*HALF_W +: HALF_W]),
      .ge   (halfGe[h])
    );
  end

  for (genvar g = 0; g < 4; g++) begin : g_byte
    simd_lane #(.W(BYTE_W)) u_lane (
      .a    (opA[g*BYTE_W +: BYTE_W]),
      .b    (opB[g*BYTE_W +: BYTE_W]),
      .sub  (strobes.hiSub),
      .uns  (strobes.unsignedOp),
      .flav (strobes.flav),
      .res  (byteWord[g*BYTE_W +: BYTE_W]),
      .ge   (byteGe[g])
    );
  end

  simd_sad #(.DATA_W(DATA_W)) u_sad (
    .opA    (opA),
    .opB    (opB),
    .accIn  (accIn),
    .accAdd (strobes.accAdd),
    .sum    (sadWord)
  );

  always_comb begin
    if (strobes.sadSel)        result = sadWord;
    else if (strobes.byteMode) result = byteWord;
    else                       result = halfWord;

    if (!strobes.geWe)         geFlags = '0;
    else if (strobes.byteMode) geFlags = byteGe;
    else                       geFlags = {halfGe[1], halfGe[1], halfGe[0], halfGe[0]};
  end

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] accIn,
  input  logic [SEL_W-1:0]  opSel,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        geFlags,
  output logic              geWrite
);

  strobe_t strobes;

  simd_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  simd_dp #(.DATA_W(DATA_W)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .accIn   (accIn),
    .strobes (strobes),
    .result  (result),
    .geFlags (geFlags)
  );

  assign geWrite = strobes.geWe;

endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int DATA_W = 32
) (
  input logic [DATA_W-1:0]          opA,
  input logic [simd_pkg::SEL_W-1:0] opSel,
  input logic [DATA_W-1:0]          result,
  input logic [3:0]                 geFlags,
  input logic                       geWrite
);

  localparam int BW = DATA_W / 4;
  localparam logic [DATA_W-1:0] SAD_MAX = DATA_W'(4 * ((2 ** BW) - 1));

  always_comb begin
    // R6: flags stay quiet when not written
    if (!geWrite) a_r6_ge_quiet: assert (geFlags == 4'b0000);
    // R6: write strobe only for modular lane operations
    if (geWrite) a_r6_we_modular: assert (opSel[1:0] == 2'b00 && opSel[5:4] != 2'b11);
    // R8: halfword lanes fill flag pairs
    if (geWrite && !opSel[5])
      a_r8_half_pairs: assert (geFlags[3] == geFlags[2] && geFlags[1] == geFlags[0]);
    // R9: plain difference sum is bounded by four byte maxima
    if (opSel[5:3] == 3'd6) a_r9_sad_bound: assert (result <= SAD_MAX);
    // R4: unsigned saturating byte add never drops below the first operand
    if (opSel == 6'b100_101) begin
      for (int i = 0; i < 4; i++) begin
        a_r4_usat_floor: assert (result[i*BW +: BW] >= opA[i*BW +: BW]);
      end
    end
  end

endmodule

bind simd_addsub simd_addsub_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/simd_addsub_tb.sv
module simd_addsub_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0, accIn = '0;
  logic [5:0]  opSel = '0;
  logic [31:0] result;
  logic [3:0]  geFlags;
  logic        geWrite;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  simd_addsub u_dut (
    .opA(opA), .opB(opB), .accIn(accIn), .opSel(opSel),
    .result(result), .geFlags(geFlags), .geWrite(geWrite)
  );

  function automatic void laneModel(input longint a, input longint b, input bit sub,
                                    input bit uns, input int fl, input int w,
                                    output longint r, output bit g);
    longint m, sa, sb, s;
    m  = 64'(1) << w;
    sa = a;
    sb = b;
    if (!uns) begin
      if (sa >= m / 2) sa -= m;
      if (sb >= m / 2) sb -= m;
    end
    s = sub ? sa - sb : sa + sb;
    g = (uns && !sub) ? (s >= m) : (s >= 0);
    if (fl == 0) r = s;
    else if (fl == 1) begin
      if (uns) r = (s < 0) ? 0 : ((s > m - 1) ? m - 1 : s);
      else     r = (s < -(m / 2)) ? -(m / 2) : ((s > m / 2 - 1) ? m / 2 - 1 : s);
    end else r = s >>> 1;
    r = r & (m - 1);
  endfunction

  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] acc, input logic [5:0] sel,
                                output logic [31:0] res, output logic [3:0] ge,
                                output logic we);
    int     op, fl;
    bit     uns, g0, g1;
    longint r0, r1, sad;
    op  = int'(sel[5:3]);
    uns = sel[2];
    fl  = (sel[1:0] >= 2) ? 2 : int'(sel[1:0]);
    we  = (op < 6) && (sel[1:0] == 2'b00);
    ge  = '0;
    res = '0;
    if (op < 4) begin
      bit hs, ls, cr;
      hs = (op == 2) || (op == 3);
      ls = (op == 1) || (op == 3);
      cr = (op == 1) || (op == 2);
      laneModel(a[31:16], cr ? b[15:0] : b[31:16], hs, uns, fl, 16, r1, g1);
      laneModel(a[15:0],  cr ? b[31:16] : b[15:0], ls, uns, fl, 16, r0, g0);
      res = {r1[15:0], r0[15:0]};
      if (we) ge = {g1, g1, g0, g0};
    end else if (op < 6) begin
      for (int i = 0; i < 4; i++) begin
        laneModel(a[i*8 +: 8], b[i*8 +: 8], op == 5, uns, fl, 8, r0, g0);
        res[i*8 +: 8] = r0[7:0];
        if (we) ge[i] = g0;
      end
    end else begin
      sad = 0;
      for (int i = 0; i < 4; i++) begin
        longint d;
        d = longint'(a[i*8 +: 8]) - longint'(b[i*8 +: 8]);
        sad += (d < 0) ? -d : d;
      end
      if (op == 7) sad += longint'(acc);
      res = sad[31:0];
    end
  endfunction

  function automatic string resTag(input logic [5:0] sel);
    if (sel[5:4] == 2'b11) return "R9";
    if (sel[1:0] == 2'b01) return "R4";
    if (sel[1:0] == 2'b11) return "R3";
    if (sel[1:0] == 2'b10) return "R5";
    if (sel[5:3] == 3'd1 || sel[5:3] == 3'd2) return "R2";
    return "R1";
  endfunction

  task automatic runOne(input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc,
                        input logic [5:0] sel, input string tagOverride);
    logic [31:0] eRes;
    logic [3:0]  eGe;
    logic        eWe;
    string       tRes, tGe;
    @(posedge clk);
    opA   = a;
    opB   = b;
    accIn = acc;
    opSel = sel;
    @(negedge clk);
    model(a, b, acc, sel, eRes, eGe, eWe);
    tRes = (tagOverride != "") ? tagOverride : resTag(sel);
    tGe  = (tagOverride != "") ? tagOverride : (!eWe ? "R6" : (sel[5] ? "R7" : "R8"));
    nChecks += 3;
    if (result !== eRes) begin
      nFails++;
      $display("FAIL %s result sel=%b a=%h b=%h acc=%h: got %h expected %h",
               tRes, sel, a, b, acc, result, eRes);
    end
    if (geFlags !== eGe) begin
      nFails++;
      $display("FAIL %s geFlags sel=%b a=%h b=%h: got %b expected %b",
               tGe, sel, a, b, geFlags, eGe);
    end
    if (geWrite !== eWe) begin
      nFails++;
      $display("FAIL R6 geWrite sel=%b: got %b expected %b", sel, geWrite, eWe);
    end
  endtask

  logic [31:0] edgeWords [12] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_8000, 32'h7FFF_7FFF,
    32'h8080_8080, 32'h7F7F_7F7F, 32'h0101_0101, 32'h0001_FFFF,
    32'h1234_5678, 32'hFF00_FF00, 32'h00FF_00FF, 32'h8000_7FFF
  };

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1: idle state, zero inputs with halfword add: zero result, all flags set
    runOne(32'h0, 32'h0, 32'h0, 6'b000_000, "R1");

    // R3: flavour 11 behaves as halving (signed halfword add of 0x7FFF+1 -> 0x4000)
    runOne(32'h7FFF_0001, 32'h0001_0001, 32'h0, 6'b000_011, "R3");
    // R7: unsigned byte subtract, borrow by one clears the flag
    runOne(32'h0000_0000, 32'h0000_0001, 32'h0, 6'b101_100, "R7");
    // R5: unsigned halving byte subtract of -1 -> 0xFF
    runOne(32'h0000_0000, 32'h0000_0001, 32'h0, 6'b101_110, "R5");

    // R10: accumulator must not influence non-accumulating operations
    for (int op = 0; op < 7; op++) begin
      for (int fl = 0; fl < 8; fl++) begin
        runOne(32'h9A3C_51E7, 32'h47F0_C28B, 32'hDEAD_BEEF, 6'((op << 3) | fl), "R10");
      end
    end

    // Edge-word sweep over every select code
    for (int s = 0; s < 64; s++) begin
      for (int i = 0; i < 12; i++) begin
        for (int j = 0; j < 12; j++) begin
          runOne(edgeWords[i], edgeWords[j], edgeWords[(i + j) % 12], 6'(s), "");
        end
      end
    end

    // Random operands over every select code
    for (int k = 0; k < 100; k++) begin
      logic [31:0] ra, rb, rc;
      ra = $urandom;
      rb = $urandom;
      rc = $urandom;
      for (int s = 0; s < 64; s++) begin
        runOne(ra, rb, rc, 6'(s), "");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not complete within %0d cycles", WD_CYCLES);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule